// File: doc/BRIEF.md
# ADC Trigger and Buffer Interrupt Controller

This block sits between a set of event sources and an analog-to-digital conversion sequencer. Five single-cycle event strobes come in: an external pin event, a timer event, an input-capture event, a compare-match event and a PWM rising-edge event. An 8-bit control register holds a per-source enable mask. The block merges every enabled strobe into one conversion-start pulse.

The converter writes its results into a four-entry buffer and pulses a write strobe for each word. The block follows the buffer position with a wrapping 2-bit counter and raises an interrupt pulse. In continuous loop mode, a two-bit depth select in the control register picks the words that interrupt. In single-shot mode, every completed write interrupts and the depth select has no effect.

Top module: `adc_trig_irq`

## Requirements
- R1: After reset, the control register reads 0x00, and both `conv_start` and `buf_irq` are low.
- R2: A write to the control register stores bits 7:6 and 4:0. Bit 5 always reads back as 0.
- R3: A strobe on `trig_in[i]` whose mask bit i (control bits 4:0, bit 0 = external pin event, bit 1 = timer, bit 2 = input capture, bit 3 = compare match, bit 4 = PWM rising edge) is set makes `conv_start` high for exactly one cycle, in the cycle after the strobe. Strobes whose mask bit is clear have no effect. Several enabled strobes in the same cycle give one single pulse.
- R4: With mask 00000, no strobe pattern ever produces `conv_start`.
- R5: In loop mode (`loop_mode`=1) with depth select (control bits 7:6) = 00, every buffer write raises `buf_irq`.
- R6: In loop mode with depth select = 01, the interrupt is raised on the 2nd and 4th words of each group of four, and not on the 1st or 3rd.
- R7: In loop mode with depth select = 10, the interrupt is raised on the 4th word only.
- R8: In loop mode with depth select = 11, no buffer interrupt is ever raised.
- R9: In single-shot mode (`loop_mode`=0), every buffer write raises `buf_irq`, whatever the depth select.
- R10: The buffer position wraps from the 4th word back to the 1st. Any change of `loop_mode` puts the position back to the 1st word, and a write made in the cycle of the change counts as the 1st word.
- R11: `buf_irq` is a one-cycle pulse in the cycle after the qualifying `buf_wr`. It is never high without a write in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| trig_in | input | 5 | Event strobes, one per source |
| loop_mode | input | 1 | 1 = continuous loop, 0 = single shot |
| buf_wr | input | 1 | Result word written to buffer |
| conv_start | output | 1 | Conversion-start pulse |
| buf_irq | output | 1 | Buffer interrupt pulse |

## Verification
The bench walks four or more writes through each depth select. A design with the even-word decode off by one would interrupt on the 1st and 3rd words. A design with a counter that does not wrap would stay silent on the second group. It toggles the mode partway through a group, so that a counter that survives the change shows up as a misplaced interrupt. It also drives simultaneous and masked strobes, which catches a start output that stretches over two cycles or ignores the mask. Depth select 11 and the single-shot case with a non-zero select catch designs that treat the reserved code as a real depth or that apply the depth in the wrong mode.

// File: rtl/adc_trig_irq.sv
module adc_trig_irq #(
  parameter int NSRC  = 5,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic [NSRC-1:0] trig_in,
  input  logic            loop_mode,
  input  logic            buf_wr,
  output logic            conv_start,
  output logic            buf_irq
);
  localparam int CW = $clog2(DEPTH);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [NSRC-1:0] mask_q;
  logic [1:0]      sel_q;
  logic [CW-1:0]   cnt_q;
  logic            loop_q;
  logic            start_q;
  logic            irq_q;
  logic            hit;

  wire           mode_chg = loop_mode != loop_q;
  wire [CW-1:0]  pos      = mode_chg ? '0 : cnt_q;

  assign cfg_rdata  = {sel_q, 1'b0, mask_q};
  assign conv_start = start_q;
  assign buf_irq    = irq_q;

  always_comb begin
    if (!loop_mode) hit = 1'b1;
    else begin
      case (sel_q)
        2'b00:   hit = 1'b1;
        2'b01:   hit = pos[0];
        2'b10:   hit = pos == LAST;
        default: hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      sel_q   <= '0;
      cnt_q   <= '0;
      loop_q  <= 1'b0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (cfg_we) begin
        mask_q <= cfg_wdata[NSRC-1:0];
        sel_q  <= cfg_wdata[7:6];
      end
      loop_q  <= loop_mode;
      start_q <= |(trig_in & mask_q);
      irq_q   <= buf_wr & hit;
      cnt_q   <= pos + CW'(buf_wr);
    end
  end

  assert_start_has_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(|trig_in));

  assert_no_start_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_rdata[4:0]) == 5'd0) |-> !conv_start);

  assert_irq_has_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_irq |-> $past(buf_wr));

  assert_no_irq_sel3_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && cfg_rdata[7:6] == 2'b11) |=> !buf_irq);

  assert_single_shot_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && !loop_mode) |=> buf_irq);

  assert_pos_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && !mode_chg && cnt_q == LAST) |=> cnt_q == '0);
endmodule

// File: tb/adc_trig_irq_tb_top.sv
module adc_trig_irq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [4:0] trig_in = '0;
  logic loop_mode = 1'b0;
  logic buf_wr = 1'b0;
  logic conv_start, buf_irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_trig_irq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .trig_in(trig_in), .loop_mode(loop_mode),
    .buf_wr(buf_wr), .conv_start(conv_start), .buf_irq(buf_irq));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); loop_mode = m;
    @(negedge clk);
  endtask

  task automatic strobe(input logic [4:0] v, input int exp, input string req);
    @(negedge clk); trig_in = v;
    @(negedge clk); trig_in = '0;
    check(req, conv_start, exp);
    @(negedge clk);
    check(req, conv_start, 0);
  endtask

  task automatic wr_expect(input int exp, input string req);
    @(negedge clk); buf_wr = 1'b1;
    @(negedge clk); buf_wr = 1'b0;
    check(req, buf_irq, exp);
  endtask

  task automatic t_reset;
    check("R1", cfg_rdata, 0);
    check("R1", conv_start, 0);
    check("R1", buf_irq, 0);
  endtask

  task automatic t_readback;
    cfg(8'hFF);
    check("R2", cfg_rdata, 8'hDF);
    cfg(8'h65);
    check("R2", cfg_rdata, 8'h45);
  endtask

  task automatic t_start;
    cfg(8'h05);
    strobe(5'b00001, 1, "R3");
    strobe(5'b00100, 1, "R3");
    strobe(5'b11010, 0, "R3");
    strobe(5'b00101, 1, "R3");
    cfg(8'h1F);
    strobe(5'b11111, 1, "R3");
    strobe(5'b10000, 1, "R3");
  endtask

  task automatic t_zero_mask;
    cfg(8'h00);
    strobe(5'b11111, 0, "R4");
    strobe(5'b01000, 0, "R4");
  endtask

  task automatic t_sel00;
    set_mode(1'b1);
    cfg(8'h00);
    for (int i = 0; i < 5; i++) wr_expect(1, "R5");
    @(negedge clk);
    check("R11", buf_irq, 0);
  endtask

  task automatic t_sel01;
    set_mode(1'b0); set_mode(1'b1);
    cfg(8'h40);
    for (int g = 0; g < 2; g++) begin
      wr_expect(0, "R6"); wr_expect(1, "R6");
      wr_expect(0, "R6"); wr_expect(1, "R10");
    end
  endtask

  task automatic t_sel10;
    set_mode(1'b0); set_mode(1'b1);
    cfg(8'h80);
    for (int g = 0; g < 2; g++) begin
      wr_expect(0, "R7"); wr_expect(0, "R7");
      wr_expect(0, "R7"); wr_expect(1, "R7");
    end
  endtask

  task automatic t_sel11;
    cfg(8'hC0);
    for (int i = 0; i < 6; i++) wr_expect(0, "R8");
  endtask

  task automatic t_single;
    cfg(8'h80);
    set_mode(1'b0);
    for (int i = 0; i < 3; i++) wr_expect(1, "R9");
    cfg(8'hC0);
    wr_expect(1, "R9");
  endtask

  task automatic t_mode_reset;
    cfg(8'h80);
    set_mode(1'b1);
    wr_expect(0, "R10"); wr_expect(0, "R10"); wr_expect(0, "R10");
    set_mode(1'b0); set_mode(1'b1);
    wr_expect(0, "R10"); wr_expect(0, "R10"); wr_expect(0, "R10");
    wr_expect(1, "R10");
    cfg(8'h40);
    wr_expect(0, "R10");
    @(negedge clk); loop_mode = 1'b0; buf_wr = 1'b1;
    @(negedge clk); loop_mode = 1'b1; buf_wr = 1'b1;
    @(negedge clk); buf_wr = 1'b0;
    check("R10", buf_irq, 0);
    wr_expect(1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_readback;
    t_start;
    t_zero_mask;
    t_sel00;
    t_sel01;
    t_sel10;
    t_sel11;
    t_single;
    t_mode_reset;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule